// File: doc/BRIEF.md
# Service Request and Serial Poll Responder

This block lets an instrument on a general-purpose instrument bus ask the controller for attention and answer the controller's serial poll. The instrument raises a request-service level, taken from its serially loaded configuration word. The block then asserts the service-request line and holds it until a serial poll picks up the request, or until the instrument withdraws it first.

The block keeps two small state machines. The first is a three-state request machine: no request pending (negative response), request pending, and affirmative response given. The second is a one-bit poll mode, which the poll-enable command sets and the poll-disable command or an interface clear resets. The poll-active condition is the poll mode combined with the talker-active input. While it is true, the block supplies the status bit for data line 7 in bus (inverted) polarity. It also supplies a strobe that tells the instrument to start a byte transfer through its new-byte-available input.

Top module: `srq_poll_ctl`

## Requirements
- R1: After reset, and immediately after reset is released, srq_o, rqs_o, spas_o and xfer_req_o are 0 and dio7_n_o is 1. Poll mode is off.
- R2: If rsv_i is 1 at a clock edge while no request is pending and poll-active is 0, srq_o is 1 after that edge.
- R3: If rsv_i is 0 at a clock edge while a request is pending, srq_o and rqs_o are 0 after that edge.
- R4: spe_cmd sampled at an edge turns poll mode on. From that edge, spas_o equals poll mode AND talk_act, following talk_act without delay.
- R5: spd_cmd or ifc_i sampled at an edge turns poll mode off. If spe_cmd and spd_cmd are both 1, disable wins.
- R6: A pending request seen at an edge while poll-active is 1 moves to the affirmative state. After that edge rqs_o is 1 and srq_o is 0, and the two are never 1 together.
- R7: In the affirmative state, rsv_i may drop while poll-active is 1 and rqs_o stays 1.
- R8: In the affirmative state with poll-active 0, rsv_i at 0 returns the block to no request (rqs_o 0), and rsv_i at 1 keeps rqs_o at 1.
- R9: dio7_n_o is the inverse of rqs_o while spas_o is 1, and 1 otherwise.
- R10: xfer_req_o is 1 exactly while spas_o is 1 and rqs_o is 1.
- R11: With no request pending, rsv_i at 1 does not raise srq_o while poll-active is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_por | input | 1 | Synchronous power-on reset, active high |
| rsv_i | input | 1 | Request-service bit from the configuration word |
| spe_cmd | input | 1 | Serial poll enable command received |
| spd_cmd | input | 1 | Serial poll disable command received |
| ifc_i | input | 1 | Interface clear |
| talk_act | input | 1 | Talker function in its active state |
| srq_o | output | 1 | Service request line drive (request pending) |
| rqs_o | output | 1 | Affirmative poll response state |
| spas_o | output | 1 | Serial poll active |
| dio7_n_o | output | 1 | Status bit for data line 7, bus polarity |
| xfer_req_o | output | 1 | Instrument must start a status byte transfer |

## Verification
Changes to the request state and the poll mode appear one clock edge after the inputs that cause them. spas_o, dio7_n_o and xfer_req_o also follow talk_act combinationally within the same cycle. The bench drives each vector on the falling edge and samples one time unit after the next rising edge. Each expected value therefore reflects exactly one edge of state change plus the inputs still applied. Entering the affirmative state takes two edges after poll enable: one to set poll mode and one for the request machine to see poll-active. The vector table spaces its expectations to match.

// File: rtl/srq_poll_ctl.sv
module srq_poll_ctl (
  input  logic clk,
  input  logic rst_por,
  input  logic rsv_i,
  input  logic spe_cmd,
  input  logic spd_cmd,
  input  logic ifc_i,
  input  logic talk_act,
  output logic srq_o,
  output logic rqs_o,
  output logic spas_o,
  output logic dio7_n_o,
  output logic xfer_req_o
);

  typedef enum logic [1:0] {SR_NONE = 2'd0, SR_REQ = 2'd1, SR_AFF = 2'd2} sr_t;

  sr_t  sr_q, sr_d;
  logic poll_q;
  logic poll_act;

  assign poll_act = poll_q & talk_act;

  always_comb begin
    sr_d = sr_q;
    case (sr_q)
      SR_NONE: if (rsv_i && !poll_act) sr_d = SR_REQ;
      SR_REQ:  if (!rsv_i)             sr_d = SR_NONE;
               else if (poll_act)      sr_d = SR_AFF;
      SR_AFF:  if (!rsv_i && !poll_act) sr_d = SR_NONE;
      default: sr_d = SR_NONE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst_por) begin
      sr_q   <= SR_NONE;
      poll_q <= 1'b0;
    end else begin
      sr_q <= sr_d;
      if (spd_cmd || ifc_i) poll_q <= 1'b0;
      else if (spe_cmd)     poll_q <= 1'b1;
    end
  end

  assign srq_o      = (sr_q == SR_REQ);
  assign rqs_o      = (sr_q == SR_AFF);
  assign spas_o     = poll_act;
  assign dio7_n_o   = poll_act ? !rqs_o : 1'b1;
  assign xfer_req_o = poll_act & rqs_o;

endmodule

// File: rtl/srq_poll_ctl_chk.sv
module srq_poll_ctl_chk (
  input logic clk,
  input logic rst_por,
  input logic rsv_i,
  input logic spd_cmd,
  input logic ifc_i,
  input logic srq_o,
  input logic rqs_o,
  input logic spas_o
);

  AST_SRQ_RQS_EXCL: assert property (@(posedge clk) disable iff (rst_por) !(srq_o && rqs_o)); // R6
  AST_RSV_RAISE: assert property (@(posedge clk) disable iff (rst_por)
    (rsv_i && !spas_o && !srq_o && !rqs_o) |=> srq_o); // R2
  AST_RSV_DROP: assert property (@(posedge clk) disable iff (rst_por)
    (srq_o && !rsv_i) |=> (!srq_o && !rqs_o)); // R3
  AST_APRS_ENTRY: assert property (@(posedge clk) disable iff (rst_por)
    (srq_o && rsv_i && spas_o) |=> rqs_o); // R6
  AST_APRS_HOLD: assert property (@(posedge clk) disable iff (rst_por)
    (rqs_o && spas_o) |=> rqs_o); // R7
  AST_POLL_EXIT: assert property (@(posedge clk) disable iff (rst_por)
    (spd_cmd || ifc_i) |=> !spas_o); // R5

endmodule

bind srq_poll_ctl srq_poll_ctl_chk chk_i (
  .clk(clk), .rst_por(rst_por), .rsv_i(rsv_i), .spd_cmd(spd_cmd), .ifc_i(ifc_i),
  .srq_o(srq_o), .rqs_o(rqs_o), .spas_o(spas_o)
);

// File: tb/srq_poll_ctl_tb.sv
module srq_poll_ctl_tb_top;
  logic clk = 1'b0;
  logic rst_por = 1'b1;
  logic rsv_i = 1'b0, spe_cmd = 1'b0, spd_cmd = 1'b0, ifc_i = 1'b0, talk_act = 1'b0;
  logic srq_o, rqs_o, spas_o, dio7_n_o, xfer_req_o;
  int n_run = 0, n_fail = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  srq_poll_ctl dut_i (
    .clk(clk), .rst_por(rst_por), .rsv_i(rsv_i), .spe_cmd(spe_cmd), .spd_cmd(spd_cmd),
    .ifc_i(ifc_i), .talk_act(talk_act), .srq_o(srq_o), .rqs_o(rqs_o), .spas_o(spas_o),
    .dio7_n_o(dio7_n_o), .xfer_req_o(xfer_req_o)
  );

  // inputs {rsv, spe, spd, ifc, talk} ; outputs {srq, rqs, spas, dio7_n, xfer_req}
  localparam int NV = 15;
  localparam logic [9:0] VEC [NV] = '{
    10'b10000_10010, 10'b11000_10010, 10'b10001_01101, 10'b00001_01101,
    10'b00000_00010, 10'b10001_00110, 10'b11101_00010, 10'b10001_10010,
    10'b11001_10110, 10'b10001_01101, 10'b10011_01010, 10'b10000_01010,
    10'b00000_00010, 10'b10000_10010, 10'b00000_00010
  };

  function automatic string tag(input int i);
    case (i)
      0, 7, 13: return "R2";
      1:        return "R4";
      2, 9:     return "R6";
      3:        return "R7";
      4, 11, 12: return "R8";
      5:        return "R11";
      6, 10:    return "R5";
      8:        return "R9 R10";
      default:  return "R3";
    endcase
  endfunction

  task automatic check(input string rq, input logic [4:0] exp);
    logic [4:0] act;
    act = {srq_o, rqs_o, spas_o, dio7_n_o, xfer_req_o};
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: outputs actual %b expected %b", rq, act, exp);
    end
  endtask

  task automatic step(input logic [4:0] ins);
    @(negedge clk);
    {rsv_i, spe_cmd, spd_cmd, ifc_i, talk_act} = ins;
    @(posedge clk);
    #1;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 check("R1", 5'b00010);
    @(negedge clk) rst_por = 1'b0;
    @(posedge clk); #1 check("R1", 5'b00010);
    for (int i = 0; i < NV; i++) begin
      step(VEC[i][9:5]);
      check(tag(i), VEC[i][4:0]);
    end
    // R9 R10: talk_act dropping removes poll-active in the same cycle
    step(5'b11001); check("R4", 5'b10110);
    step(5'b10001); check("R10", 5'b01101);
    @(negedge clk) talk_act = 1'b0; #1 check("R9", 5'b01010);
    // R1: reset in the middle of a poll clears everything
    @(negedge clk) begin rst_por = 1'b1; talk_act = 1'b1; end
    @(posedge clk); #1 check("R1", 5'b00010);
    @(negedge clk) rst_por = 1'b0;
    step(5'b00001); check("R1", 5'b00010);
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin repeat (2000) @(posedge clk); n_run++; n_fail++; $display("FAIL watchdog: actual timeout expected completion"); end
    join_any
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule